// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and saved status words of a processor that runs in one of several privilege modes. A five-bit mode value chooses which physical copy of a register a 4-bit logical index names. Two combinational read ports and one clocked write port all use the same mode value. A separate saved-status port reads and writes the status word that belongs to the current exception mode.

Storage holds 31 physical general registers. There are 16 common ones, a private set of seven for the fast-interrupt mode, and a private pair for each of the other four exception modes. There are also five saved status words, one for each exception mode. The mode input comes from the surrounding pipeline. The block does not decode instructions, does not treat index 15 in any special way, and places no limits on which registers may be accessed.

Top module: `bankreg_top`

## Requirements
- R1: A synchronous active-high reset clears every general register and every saved status word to zero.
- R2: Logical indices 0 to 7 name the same physical register in every mode.
- R3: User mode (10000) and System mode (11111) share one set of physical registers for indices 8 to 14. Index 15 is one common register in every mode.
- R4: In fast-interrupt mode (10001), indices 8 to 14 name seven registers that belong only to that mode.
- R5: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 name a pair that belongs only to that mode. Indices 8 to 12 stay shared with User mode.
- R6: Only the seven encodings listed in R3 to R5 select a banked view. Each of them selects its own distinct pair or set.
- R7: Any other mode encoding accesses the User-mode registers and has no saved status word. Its saved-status reads return zero and its saved-status writes are dropped.
- R8: Each of the five exception modes has its own saved status word. A write in one exception mode never changes the saved status word of another mode.
- R9: In User and System modes, the saved-status read returns zero and saved-status writes have no effect on any stored word.
- R10: Reads are combinational. A write takes effect at the rising clock edge and uses the bank chosen by the mode in that same cycle.
- R11: When a read and a write in the same cycle target the same physical register or saved status word, the read returns the data being written.
- R12: The two read ports work independently and may read any two indices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode encoding |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | DATA_W | General register write data |
| spsr_rd_data | output | DATA_W | Saved status word of the current mode, or zero |
| spsr_wr_en | input | 1 | Saved status write enable |
| spsr_wr_data | input | DATA_W | Saved status write data |

## Verification
A wrong bank mapping does not show up at the moment of the faulty write. It shows up later, when a register is read in a different mode and returns a value written by another mode's copy, or loses a value that should have survived a mode switch. Errors in the bypass path or in the saved-status gating show up in the same cycle, on the read data. For this reason the stimulus switches mode on almost every cycle and reads back from a reference image across modes. Directed cases write in one exception mode and read in its neighbours.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef enum logic [2:0] {
        BK_BASE = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    localparam int LOG_REGS    = 16;
    localparam int IDX_W       = $clog2(LOG_REGS);
    localparam int BASE_REGS   = 16;
    localparam int FIQ_FIRST   = 8;
    localparam int FIQ_BANKED  = 7;
    localparam int EXC_FIRST   = 13;
    localparam int EXC_BANKED  = 2;
    localparam int EXC_MODES   = 4;
    localparam int PHYS_REGS   = BASE_REGS + FIQ_BANKED + EXC_MODES * EXC_BANKED;
    localparam int PHYS_W      = $clog2(PHYS_REGS);
    localparam int SPSR_SLOTS  = 1 + EXC_MODES;
    localparam int SLOT_W      = $clog2(SPSR_SLOTS);

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } spsr_sel_t;

    function automatic bank_e mode_to_bank(input logic [4:0] m);
        case (m)
            MODE_FIQ: return BK_FIQ;
            MODE_IRQ: return BK_IRQ;
            MODE_SVC: return BK_SVC;
            MODE_ABT: return BK_ABT;
            MODE_UND: return BK_UND;
            default:  return BK_BASE;
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] phys_of(input bank_e b, input logic [IDX_W-1:0] idx);
        int n;
        n = int'(idx);
        if (b == BK_FIQ && n >= FIQ_FIRST && n < FIQ_FIRST + FIQ_BANKED)
            return PHYS_W'(BASE_REGS + n - FIQ_FIRST);
        if (b != BK_BASE && b != BK_FIQ && n >= EXC_FIRST && n < EXC_FIRST + EXC_BANKED)
            return PHYS_W'(BASE_REGS + FIQ_BANKED
                           + EXC_BANKED * (int'(b) - int'(BK_IRQ)) + n - EXC_FIRST);
        return PHYS_W'(n);
    endfunction

    function automatic spsr_sel_t spsr_of(input bank_e b);
        spsr_sel_t s;
        s.valid = (b != BK_BASE);
        s.slot  = s.valid ? SLOT_W'(int'(b) - int'(BK_FIQ)) : '0;
        return s;
    endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
    import bankreg_pkg::*;
(
    input  bank_e                 bank,
    input  logic [IDX_W-1:0]      idx,
    output logic [PHYS_W-1:0]     phys
);
    always_comb phys = phys_of(bank, idx);
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NRD    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [PHYS_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [PHYS_W-1:0]  rd_addr [NRD],
    output logic [DATA_W-1:0]  rd_data [NRD]
);
    logic [DATA_W-1:0] regs [PHYS_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (wr_en && wr_addr == rd_addr[g]) rd_data[g] = wr_data;
            else                                rd_data[g] = regs[rd_addr[g]];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !wr_en) |-> (rd_data[0] == '0)); // R1

endmodule

// File: rtl/bankreg_spsr.sv
module bankreg_spsr
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bank_e              bank,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    spsr_sel_t               sel;
    logic [SPSR_SLOTS-1:0]   slot_we;
    logic [DATA_W-1:0]       store [SPSR_SLOTS];

    always_comb sel = spsr_of(bank);

    for (genvar s = 0; s < SPSR_SLOTS; s++) begin : g_slot
        assign slot_we[s] = we && sel.valid && (sel.slot == SLOT_W'(s));
        always_ff @(posedge clk) begin
            if (rst)             store[s] <= '0;
            else if (slot_we[s]) store[s] <= wdata;
        end
    end

    always_comb begin
        if (!sel.valid) rdata = '0;
        else if (we)    rdata = wdata;
        else            rdata = store[sel.slot];
    end

    AST_SPSR_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_we)); // R8

endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] spsr_rd_data,
    input  logic              spsr_wr_en,
    input  logic [DATA_W-1:0] spsr_wr_data
);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    bank_e              bank;
    logic [IDX_W-1:0]   lidx [NPORT];
    logic [PHYS_W-1:0]  phys [NPORT];
    logic [PHYS_W-1:0]  rd_phys [NRD];
    logic [DATA_W-1:0]  rd_out  [NRD];

    always_comb bank = mode_to_bank(mode);

    assign lidx[0] = rd_a_idx;
    assign lidx[1] = rd_b_idx;
    assign lidx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bankreg_map u_map (.bank(bank), .idx(lidx[p]), .phys(phys[p]));
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rdp
        assign rd_phys[r] = phys[r];
    end

    bankreg_gpr #(.DATA_W(DATA_W), .NRD(NRD)) u_gpr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(phys[NRD]),
        .wr_data(wr_data),
        .rd_addr(rd_phys),
        .rd_data(rd_out)
    );

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];

    bankreg_spsr #(.DATA_W(DATA_W)) u_spsr (
        .clk  (clk),
        .rst  (rst),
        .bank (bank),
        .we   (spsr_wr_en),
        .wdata(spsr_wr_data),
        .rdata(spsr_rd_data)
    );

    AST_LOW_SHARED: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx < 4'd8) |-> (phys[0] == PHYS_W'(rd_a_idx))); // R2

    AST_PHYS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phys[NRD] < PHYS_W'(PHYS_REGS))); // R6

    AST_NO_SPSR_USER: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_USR || mode == MODE_SYS) |-> (spsr_rd_data == '0)); // R9

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && mode == $past(mode) && rd_a_idx == $past(wr_idx)
         && !(wr_en && wr_idx == rd_a_idx)) |-> (rd_a_data == $past(wr_data))); // R10

    AST_BYPASS_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data)); // R11

endmodule

// File: tb/test_bankreg_top.sv
module test_bankreg_top;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    mode = 5'b10000;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, spsr_rd_data;
    logic          wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0, spsr_wr_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [DW-1:0] ref_gpr  [31];
    logic [DW-1:0] ref_spsr [5];

    always #10 clk = ~clk;

    bankreg_top #(.DATA_W(DW)) i_bankreg_top (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .spsr_rd_data(spsr_rd_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data)
    );

    // Reference location: 0..15 common, 16..22 fast-interrupt, then pairs for IRQ, SVC, ABT, UND
    function automatic int ref_loc(input logic [4:0] m, input logic [3:0] i);
        if (m == 5'b10001 && i >= 8 && i <= 14) return 16 + int'(i) - 8;
        if (i == 13 || i == 14) begin
            if (m == 5'b10010) return 23 + int'(i) - 13;
            if (m == 5'b10011) return 25 + int'(i) - 13;
            if (m == 5'b10111) return 27 + int'(i) - 13;
            if (m == 5'b11011) return 29 + int'(i) - 13;
        end
        return int'(i);
    endfunction

    function automatic int ref_slot(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic bit legal(input logic [4:0] m);
        return m == 5'b10000 || m == 5'b11111 || ref_slot(m) >= 0;
    endfunction

    function automatic string gpr_tag(input logic [4:0] m, input logic [3:0] i);
        if (i < 8)            return "R2";
        if (i == 15)          return "R3";
        if (!legal(m))        return "R7";
        if (m == 5'b10001)    return "R4";
        if (ref_slot(m) >= 0) return "R5";
        return "R3";
    endfunction

    function automatic logic [4:0] pick_mode();
        logic [4:0] tbl [10] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                                 5'b11011, 5'b11111, 5'b00000, 5'b10100, 5'b11010};
        int k = int'($urandom % 10);
        return tbl[k];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check before rising edge, update reference after it
    task automatic step(input logic [4:0] m, input logic [3:0] a, input logic [3:0] b,
                        input bit we, input logic [3:0] wi, input logic [DW-1:0] wd,
                        input bit swe, input logic [DW-1:0] sd, input string tag);
        int la, lb, lw, sl;
        logic [DW-1:0] ea, eb, es;
        mode = m; rd_a_idx = a; rd_b_idx = b;
        wr_en = we; wr_idx = wi; wr_data = wd;
        spsr_wr_en = swe; spsr_wr_data = sd;
        la = ref_loc(m, a); lb = ref_loc(m, b); lw = ref_loc(m, wi); sl = ref_slot(m);
        ea = (we && lw == la) ? wd : ref_gpr[la];
        eb = (we && lw == lb) ? wd : ref_gpr[lb];
        es = (sl < 0) ? '0 : (swe ? sd : ref_spsr[sl]);
        #5;
        check(tag != "" ? tag : ((we && lw == la) ? "R11" : gpr_tag(m, a)), "port A", rd_a_data, ea);
        check(tag != "" ? tag : ((we && lw == lb) ? "R11" : gpr_tag(m, b)), "port B", rd_b_data, eb);
        check(tag != "" ? tag : (sl < 0 ? (legal(m) ? "R9" : "R7") : "R8"), "saved status", spsr_rd_data, es);
        @(posedge clk);
        if (we) ref_gpr[lw] = wd;
        if (swe && sl >= 0) ref_spsr[sl] = sd;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 31; i++) ref_gpr[i] = '0;
        for (int i = 0; i < 5; i++)  ref_spsr[i] = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset, in several modes
        for (int i = 0; i < 16; i++) step(5'b10000, 4'(i), 4'(15 - i), 0, 0, 0, 0, 0, "R1");
        step(5'b10001, 4'd9, 4'd14, 0, 0, 0, 0, 0, "R1");
        step(5'b11011, 4'd13, 4'd14, 0, 0, 0, 0, 0, "R1");

        // R4: fast-interrupt copy of r9 is private
        step(5'b10001, 4'd0, 4'd0, 1, 4'd9, 32'hAAAA_0009, 0, 0, "R4");
        step(5'b10000, 4'd9, 4'd9, 0, 0, 0, 0, 0, "R4");
        step(5'b10001, 4'd9, 4'd8, 0, 0, 0, 0, 0, "R4");
        // R3: User and System share r10
        step(5'b11111, 4'd0, 4'd0, 1, 4'd10, 32'h5151_0010, 0, 0, "R3");
        step(5'b10000, 4'd10, 4'd15, 0, 0, 0, 0, 0, "R3");
        // R5 / R6: supervisor r13 is hidden from interrupt mode; r12 stays shared
        step(5'b10011, 4'd0, 4'd0, 1, 4'd13, 32'h5C5C_0013, 0, 0, "R5");
        step(5'b10010, 4'd13, 4'd12, 0, 0, 0, 0, 0, "R6");
        step(5'b10011, 4'd13, 4'd14, 0, 0, 0, 0, 0, "R5");
        step(5'b10011, 4'd0, 4'd0, 1, 4'd12, 32'h0000_C012, 0, 0, "R5");
        step(5'b10111, 4'd12, 4'd13, 0, 0, 0, 0, 0, "R5");
        // R10: write uses the mode of its own cycle
        step(5'b10111, 4'd1, 4'd2, 1, 4'd14, 32'hAB70_0014, 0, 0, "R10");
        step(5'b11011, 4'd14, 4'd14, 0, 0, 0, 0, 0, "R10");
        step(5'b10111, 4'd14, 4'd13, 0, 0, 0, 0, 0, "R10");
        // R9: saved-status writes in User/System are dropped, nothing else changes
        step(5'b10000, 4'd0, 4'd0, 0, 0, 0, 1, 32'hDEAD_BEEF, "R9");
        step(5'b11111, 4'd0, 4'd0, 0, 0, 0, 1, 32'hBEEF_DEAD, "R9");
        step(5'b10010, 4'd0, 4'd0, 0, 0, 0, 0, 0, "R9");
        // R8: each exception mode keeps its own saved status
        step(5'b10010, 4'd0, 4'd0, 0, 0, 0, 1, 32'h0000_1111, "R8");
        step(5'b10001, 4'd0, 4'd0, 0, 0, 0, 0, 0, "R8");
        step(5'b10010, 4'd0, 4'd0, 0, 0, 0, 0, 0, "R8");
        // R7: unlisted encoding uses User registers and drops saved-status writes
        step(5'b00110, 4'd10, 4'd13, 0, 0, 0, 1, 32'h7777_7777, "R7");
        step(5'b10011, 4'd0, 4'd0, 0, 0, 0, 0, 0, "R7");
        // R11 / R12: both ports bypass a same-cycle write
        step(5'b10000, 4'd3, 4'd3, 1, 4'd3, 32'h1234_5678, 0, 0, "R11");
        step(5'b10001, 4'd3, 4'd11, 1, 4'd11, 32'h0F0F_0011, 1, 32'h5A5A_0001, "R12");

        // Random traffic, mode changes nearly every cycle
        for (int t = 0; t < 4000; t++) begin
            step(pick_mode(), 4'($urandom), 4'($urandom), ($urandom % 3) != 0, 4'($urandom),
                 $urandom, ($urandom % 4) == 0, $urandom, "");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule